// File: doc/BRIEF.md
# Multiplexed-Bus RAM and Parallel-Port Interface

This block is a bus slave on an 8-bit multiplexed address/data bus. A host drives an address byte on the shared lines together with a memory-or-I/O select and an active-low chip enable. It then pulses the address-latch strobe. When the strobe falls, all three values are held for the following data phase. The data phase is a read, signalled by `rd_ni` low, or a write, signalled by `wr_ni` low. It goes either to a 256-byte internal RAM or to a small I/O register file.

The I/O register file holds a command register and three 8-bit parallel ports. Each port has an output latch and per-pin output enables. The command register sets each port's direction. Port C can be split into two nibbles with separate directions. The strobe, read and write inputs are synchronized to the system clock. A write commits once, on the synchronized falling edge of the write strobe. The bidirectional bus is modelled as separate data-in, data-out and output-enable signals.

Top module: `mbus_ramio`

## Requirements
- R1: On the falling edge of `ale_i` (seen after synchronization), the block latches `ad_i` as the address, along with `io_sel_i` and `ce_n_i`. Later changes on `ad_i` do not move the address of the data phase.
- R2: While the latched `ce_n_i` is 1, `ad_oe_o` stays 0 and no RAM byte, port latch or command bit changes.
- R3: A latched `io_sel_i` of 0 sends the cycle to the RAM, which is addressed by the full latched byte (256 locations). A latched `io_sel_i` of 1 sends it to the I/O registers, and the RAM is left untouched.
- R4: A RAM read drives the addressed byte on `ad_o`. A RAM write stores the `ad_i` value present at the write commit.
- R5: In I/O cycles, address bits [2:0] select the register: 0 is the command register, 1 is port A, 2 is port B and 3 is port C. Bits [7:3] are ignored. Offsets 4 to 7 read as 0x00, and writes to them have no effect.
- R6: Command bit 0 set to 1 drives all `pa_oe_o` bits to 1. Bit 1 does the same for `pb_oe_o`. Bit 2 drives `pc_oe_o[3:0]` and bit 3 drives `pc_oe_o[7:4]`, so 00 gives all of port C as inputs and 11 gives all of it as outputs. The output enables change only when a write commits.
- R7: While `rst_ni` is 0, the command register, all port latches and all pin output enables are 0. Every port is then an input and the command register reads as 0x00.
- R8: A port read returns the live pin value for each bit set as input and the output latch for each bit set as output. Port C is resolved per nibble.
- R9: A port write always updates its output latch, which appears on `pa_o`/`pb_o`/`pc_o`, even while the port is set as input.
- R10: `ad_oe_o` is 1 only while the synchronized `rd_ni` is low and the latched chip enable is low. It returns to 0 after `rd_ni` rises. A write stores the data present at the falling edge of `wr_ni`, and later changes on `ad_i` while `wr_ni` stays low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ale_i | input | 1 | Address-latch strobe; latches on its falling edge |
| ad_i | input | 8 | Bus value, sampled as the address or the write data |
| io_sel_i | input | 1 | 1 selects the I/O registers, 0 selects the RAM |
| ce_n_i | input | 1 | Chip enable, active low, latched with the address |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| ad_o | output | 8 | Read data toward the bus |
| ad_oe_o | output | 1 | Bus output enable |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 8 | Port A per-pin output enable |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 8 | Port B per-pin output enable |
| pc_i | input | 8 | Port C pin inputs |
| pc_o | output | 8 | Port C output latch |
| pc_oe_o | output | 8 | Port C per-pin output enable |

## Verification
The bench changes `ad_i` after the strobe falls. A design that latched the address at the wrong moment would then read a different RAM byte. Cycles run with the chip enable inhibited must leave both the RAM byte and the command register untouched, which catches a gate that blocks only reads. Port reads are tried with the pins and the latch holding different values, in every direction setting including the two split nibble modes, so a design that confuses input and output mode returns the wrong byte. A long write strobe with the data changed part-way through, together with a write to an I/O offset that aliases the RAM address, exposes a level-triggered write and a missing RAM/I/O routing.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned OFFW = 3;

  localparam logic [OFFW-1:0] OFF_CMD = 3'd0;
  localparam logic [OFFW-1:0] OFF_PA  = 3'd1;
  localparam logic [OFFW-1:0] OFF_PB  = 3'd2;
  localparam logic [OFFW-1:0] OFF_PC  = 3'd3;

  localparam int unsigned CMD_A_OUT  = 0;
  localparam int unsigned CMD_B_OUT  = 1;
  localparam int unsigned CMD_CL_OUT = 2;
  localparam int unsigned CMD_CH_OUT = 3;

  localparam int unsigned NPORT = 3;
  typedef logic [DW-1:0] byte_t;
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], d_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign fall_o = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/mbus_ram.sv
module mbus_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/mbus_ioregs.sv
module mbus_ioregs
  import mbus_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [OFFW-1:0] off_i,
  input  byte_t           wdata_i,
  output byte_t           rdata_o,
  output byte_t           cmd_o,
  input  byte_t           pin_i  [NPORT],
  output byte_t           lat_o  [NPORT],
  output byte_t           oe_o   [NPORT]
);
  localparam int unsigned HALF = DW / 2;

  byte_t cmd_q;
  byte_t lat_q [NPORT];
  byte_t rd_port [NPORT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      for (int p = 0; p < NPORT; p++) lat_q[p] <= '0;
    end else if (we_i) begin
      case (off_i)
        OFF_CMD: cmd_q    <= wdata_i;
        OFF_PA:  lat_q[0] <= wdata_i;
        OFF_PB:  lat_q[1] <= wdata_i;
        OFF_PC:  lat_q[2] <= wdata_i;
        default: ;
      endcase
    end
  end

  assign oe_o[0] = {DW{cmd_q[CMD_A_OUT]}};
  assign oe_o[1] = {DW{cmd_q[CMD_B_OUT]}};
  assign oe_o[2] = {{HALF{cmd_q[CMD_CH_OUT]}}, {HALF{cmd_q[CMD_CL_OUT]}}};

  // per-bit: output bits echo the latch, input bits show the pin
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign rd_port[p] = (oe_o[p] & lat_q[p]) | (~oe_o[p] & pin_i[p]);
    assign lat_o[p]   = lat_q[p];
  end

  always_comb begin
    case (off_i)
      OFF_CMD: rdata_o = cmd_q;
      OFF_PA:  rdata_o = rd_port[0];
      OFF_PB:  rdata_o = rd_port[1];
      OFF_PC:  rdata_o = rd_port[2];
      default: rdata_o = '0;
    endcase
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/mbus_ramio.sv
module mbus_ramio
  import mbus_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ale_i,
  input  logic [7:0] ad_i,
  input  logic       io_sel_i,
  input  logic       ce_n_i,
  input  logic       rd_ni,
  input  logic       wr_ni,
  output logic [7:0] ad_o,
  output logic       ad_oe_o,
  input  logic [7:0] pa_i,
  output logic [7:0] pa_o,
  output logic [7:0] pa_oe_o,
  input  logic [7:0] pb_i,
  output logic [7:0] pb_o,
  output logic [7:0] pb_oe_o,
  input  logic [7:0] pc_i,
  output logic [7:0] pc_o,
  output logic [7:0] pc_oe_o
);
  logic  ale_s, ale_fall;
  logic  rd_s, rd_fall;
  logic  wr_s, wr_fall;
  byte_t addr_q;
  logic  io_q, ce_n_q;
  logic  ram_we, io_we;
  byte_t ram_rdata, io_rdata, cmd_q;
  byte_t pin_v [NPORT];
  byte_t lat_v [NPORT];
  byte_t oe_v  [NPORT];

  mbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_ale (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ale_i), .lvl_o(ale_s), .fall_o(ale_fall));
  mbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rd_ni), .lvl_o(rd_s), .fall_o(rd_fall));
  mbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_wr (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wr_ni), .lvl_o(wr_s), .fall_o(wr_fall));

  // address phase: held from strobe fall until the next one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      io_q   <= 1'b0;
      ce_n_q <= 1'b1;
    end else if (ale_fall) begin
      addr_q <= ad_i;
      io_q   <= io_sel_i;
      ce_n_q <= ce_n_i;
    end
  end

  assign ram_we = wr_fall & ~ce_n_q & ~io_q;
  assign io_we  = wr_fall & ~ce_n_q &  io_q;

  mbus_ram #(.AW(8), .DW(DW)) u_ram (
    .clk_i(clk_i), .we_i(ram_we), .addr_i(addr_q), .wdata_i(ad_i), .rdata_o(ram_rdata));

  assign pin_v[0] = pa_i;
  assign pin_v[1] = pb_i;
  assign pin_v[2] = pc_i;

  mbus_ioregs u_io (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(io_we), .off_i(addr_q[OFFW-1:0]),
    .wdata_i(ad_i), .rdata_o(io_rdata), .cmd_o(cmd_q),
    .pin_i(pin_v), .lat_o(lat_v), .oe_o(oe_v));

  assign pa_o    = lat_v[0];
  assign pb_o    = lat_v[1];
  assign pc_o    = lat_v[2];
  assign pa_oe_o = oe_v[0];
  assign pb_oe_o = oe_v[1];
  assign pc_oe_o = oe_v[2];

  assign ad_o    = io_q ? io_rdata : ram_rdata;
  assign ad_oe_o = ~rd_s & ~ce_n_q;

  logic unused_sync;
  assign unused_sync = ale_s ^ rd_fall ^ wr_s;
endmodule

// File: rtl/mbus_ramio_chk.sv
module mbus_ramio_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ad_oe_o,
  input logic       ce_n_q,
  input logic       io_q,
  input logic       wr_fall,
  input logic [7:0] cmd_q,
  input logic [7:0] pa_oe_o,
  input logic [7:0] pb_oe_o,
  input logic [7:0] pc_oe_o
);
  assert_oe_needs_ce_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> !ce_n_q);

  assert_inhibit_keeps_cmd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_q |=> $stable(cmd_q));

  assert_ram_cycle_keeps_cmd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fall && !io_q) |=> $stable(cmd_q));

  assert_dir_only_on_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_fall |=> $stable({pa_oe_o, pb_oe_o, pc_oe_o}));

  assert_reset_inputs_R7: assert property (@(posedge clk_i)
    (rst_ni && !$past(rst_ni)) |-> (pa_oe_o == 8'h00 && pb_oe_o == 8'h00 && pc_oe_o == 8'h00));
endmodule

bind mbus_ramio mbus_ramio_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ad_oe_o(ad_oe_o), .ce_n_q(ce_n_q), .io_q(io_q),
  .wr_fall(wr_fall), .cmd_q(cmd_q), .pa_oe_o(pa_oe_o), .pb_oe_o(pb_oe_o), .pc_oe_o(pc_oe_o));

// File: tb/mbus_ramio_tb.sv
module mbus_ramio_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ale_i = 1'b0, io_sel_i = 1'b0, ce_n_i = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [7:0] ad_i = 8'h00, pa_i = 8'h00, pb_i = 8'h00, pc_i = 8'h00;
  logic [7:0] ad_o, pa_o, pa_oe_o, pb_o, pb_oe_o, pc_o, pc_oe_o;
  logic ad_oe_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] data;
    logic       oe;
    string      tag;
  } exp_t;
  exp_t sb_q[$];
  event smp_ev;

  always #5 clk_i = ~clk_i;

  mbus_ramio u_dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries when a read phase is sampled
  initial begin
    forever begin
      @(smp_ev);
      while (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        chk({it.tag, " oe"}, {7'b0, ad_oe_o}, {7'b0, it.oe});
        if (it.oe) chk(it.tag, ad_o, it.data);
      end
    end
  end

  task automatic addr_ph(input logic io, input logic ce_n, input logic [7:0] a);
    @(negedge clk_i);
    ale_i = 1'b1; ad_i = a; io_sel_i = io; ce_n_i = ce_n;
    repeat (2) @(negedge clk_i);
    ale_i = 1'b0;
    repeat (4) @(negedge clk_i);
    ad_i = 8'hC3; io_sel_i = ~io; ce_n_i = ~ce_n;   // bus moves on after the strobe
  endtask

  task automatic bus_rd(input logic io, input logic ce_n, input logic [7:0] a,
                        input logic [7:0] exp, input string tag);
    exp_t it;
    addr_ph(io, ce_n, a);
    rd_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    it.data = exp; it.oe = ~ce_n; it.tag = tag;
    sb_q.push_back(it);
    -> smp_ev;
    #1;
    @(negedge clk_i);
    rd_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R10 oe released", {7'b0, ad_oe_o}, 8'h00);
  endtask

  task automatic bus_wr(input logic io, input logic ce_n, input logic [7:0] a,
                        input logic [7:0] d);
    addr_ph(io, ce_n, a);
    ad_i = d; wr_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    wr_ni = 1'b1; ad_i = 8'h96;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R7 pa_oe in reset", pa_oe_o, 8'h00);
    chk("R7 pc_oe in reset", pc_oe_o, 8'h00);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R7 pb_oe after reset", pb_oe_o, 8'h00);
    chk("R2 oe idle", {7'b0, ad_oe_o}, 8'h00);

    // R4 / R3: RAM across the full byte range
    bus_wr(1'b0, 1'b0, 8'h10, 8'hA5);
    bus_wr(1'b0, 1'b0, 8'hFF, 8'h3C);
    bus_wr(1'b0, 1'b0, 8'h00, 8'h5A);
    bus_rd(1'b0, 1'b0, 8'h10, 8'hA5, "R4 ram 0x10");
    bus_rd(1'b0, 1'b0, 8'hFF, 8'h3C, "R4 ram 0xFF");
    bus_rd(1'b0, 1'b0, 8'h00, 8'h5A, "R3 ram 0x00");

    // R1: ad_i changes right after the strobe falls; the latched address wins
    addr_ph(1'b0, 1'b0, 8'hFF);
    ad_i = 8'h10;
    rd_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    begin
      exp_t it;
      it.data = 8'h3C; it.oe = 1'b1; it.tag = "R1 latched address";
      sb_q.push_back(it);
    end
    -> smp_ev; #1;
    @(negedge clk_i); rd_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R7 / R5: command register reads as zero after reset
    bus_rd(1'b1, 1'b0, 8'h00, 8'h00, "R7 cmd reset value");

    // R9 / R8: latch written while input; read shows pins
    pa_i = 8'h33;
    bus_wr(1'b1, 1'b0, 8'h01, 8'h81);
    chk("R9 pa latch while input", pa_o, 8'h81);
    chk("R6 pa still input", pa_oe_o, 8'h00);
    bus_rd(1'b1, 1'b0, 8'h01, 8'h33, "R8 pa input reads pins");

    // R6 / R8: port A to output
    bus_wr(1'b1, 1'b0, 8'h00, 8'h01);
    chk("R6 pa_oe all out", pa_oe_o, 8'hFF);
    chk("R6 pb_oe still in", pb_oe_o, 8'h00);
    bus_rd(1'b1, 1'b0, 8'h01, 8'h81, "R8 pa output reads latch");
    bus_rd(1'b1, 1'b0, 8'h09, 8'h81, "R5 offset alias bits 7:3");

    // R6 / R8: port C nibble split
    pc_i = 8'h3C;
    bus_wr(1'b1, 1'b0, 8'h03, 8'hA5);
    bus_wr(1'b1, 1'b0, 8'h00, 8'h04);
    chk("R6 pc low nibble out", pc_oe_o, 8'h0F);
    bus_rd(1'b1, 1'b0, 8'h03, 8'h35, "R8 pc low out high in");
    bus_wr(1'b1, 1'b0, 8'h00, 8'h08);
    chk("R6 pc high nibble out", pc_oe_o, 8'hF0);
    chk("R6 pa back to input", pa_oe_o, 8'h00);
    bus_rd(1'b1, 1'b0, 8'h03, 8'hAC, "R8 pc high out low in");
    bus_wr(1'b1, 1'b0, 8'h00, 8'h0E);
    chk("R6 pb_oe all out", pb_oe_o, 8'hFF);
    chk("R6 pc_oe all out", pc_oe_o, 8'hFF);
    pb_i = 8'h0F;
    bus_wr(1'b1, 1'b0, 8'h02, 8'h6E);
    bus_rd(1'b1, 1'b0, 8'h02, 8'h6E, "R8 pb output reads latch");

    // R5: unused offsets
    bus_wr(1'b1, 1'b0, 8'h05, 8'h77);
    bus_rd(1'b1, 1'b0, 8'h05, 8'h00, "R5 offset 5 reads zero");
    bus_rd(1'b1, 1'b0, 8'h00, 8'h0E, "R5 offset write left cmd");

    // R3: I/O write to offset 1 leaves RAM byte 1 alone
    bus_wr(1'b0, 1'b0, 8'h01, 8'h11);
    bus_wr(1'b1, 1'b0, 8'h01, 8'h22);
    bus_rd(1'b0, 1'b0, 8'h01, 8'h11, "R3 ram untouched by io");
    chk("R3 pa latch from io", pa_o, 8'h22);

    // R2: chip enable inhibited
    bus_wr(1'b0, 1'b1, 8'h10, 8'hEE);
    bus_rd(1'b0, 1'b1, 8'h10, 8'h00, "R2 inhibited read");
    bus_rd(1'b0, 1'b0, 8'h10, 8'hA5, "R2 ram kept");
    bus_wr(1'b1, 1'b1, 8'h00, 8'h00);
    chk("R2 direction kept", pb_oe_o, 8'hFF);

    // R10: one commit per falling write edge
    addr_ph(1'b1, 1'b0, 8'h01);
    ad_i = 8'h5D; wr_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    ad_i = 8'h99;
    repeat (4) @(negedge clk_i);
    wr_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R10 first data kept", pa_o, 8'h5D);

    // R7: reset mid-run
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R7 pb_oe cleared", pb_oe_o, 8'h00);
    chk("R7 pc_oe cleared", pc_oe_o, 8'h00);
    chk("R7 pa latch cleared", pa_o, 8'h00);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    bus_rd(1'b1, 1'b0, 8'h00, 8'h00, "R7 cmd cleared");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule